// File: doc/BRIEF.md
# Power-Up Reset and Clock Sequencer

This block decides when the units of a multi-unit chip get a clock and when they leave reset. After power-on it enables the bypass clock and keeps the units in reset. It waits until the PLL reports lock and the external reset pin has been released. On the next cycle it hands over to the divided unit clock (reference / 16) and releases the unit reset in the same cycle. The PLL and the clock-gating cells are outside the block. It sees the PLL only as a lock input and drives only enable outputs.

While the units run, three events can interrupt them:

- **Clock-count write.** Software writing the clock-count register pulses an input. The block then stops every unit clock for a fixed 32 reference cycles and restarts them. The stop counter runs on the reference clock, so it keeps counting while the unit clocks are gated.
- **PCI reset.** A PCI reset input sends the block back to its power-up state, but only when the reset-direction strap is set.
- **Watchdog expiry.** A watchdog expiry, when the watchdog is enabled, produces a chip-reset pulse of fixed length. The sequence then starts again from the bypass state.

The three boot straps are also checked. A forbidden combination latches an error that holds the units in reset until the next power-on reset.

Top module: `rst_clk_sequencer`

## Requirements
- R1: While `por_n` is low and on the first cycle after it rises, `bypass_clk_en`=1, `div_clk_en`=0, `unit_rst_n`=0, `chip_rst`=0 and `strap_err`=0.
- R2: In the power-up state, the block moves to the running state on the clock edge where all three of these hold: `pll_locked`=1, `ext_rst_n`=1, and no qualified PCI reset is present. In the running state `div_clk_en`=1 and `bypass_clk_en`=0. If any one of the three conditions is missing, the block stays in the bypass state. At no time are both clock enables high.
- R3: While `div_clk_en` is high, `div_tick` pulses for one cycle in every 16. The first pulse comes on the 16th cycle of enable.
- R4: `unit_rst_n` rises in the same cycle as `div_clk_en`.
- R5: A `clkcnt_wr` pulse sampled while running drops `div_clk_en` for exactly 32 cycles. During those cycles `unit_rst_n` stays 1 and `bypass_clk_en` stays 0, and further `clkcnt_wr` pulses have no effect.
- R6: When `strap_rst_dir`=1, sampling `pci_rst_n`=0 while running or stopped returns the block to the R1 output values on the next cycle. It stays there while `pci_rst_n` is low. When `strap_rst_dir`=0, `pci_rst_n` is ignored.
- R7: When `wdog_en`=1, sampling `wdog_expire`=1 while running or stopped sets `chip_rst`=1 for exactly 16 cycles. During those cycles both clock enables are 0 and `unit_rst_n`=0. The block then returns to the bypass state. When `wdog_en`=0, `wdog_expire` has no effect.
- R8: The strap vector is {`strap_prom_boot`, `strap_rst_dir`, `strap_pci_host`}. The encodings 3'b010 and 3'b011 are illegal and all others are legal. An illegal value sampled at any edge sets `strap_err` on the next cycle. `strap_err` stays set until `por_n` falls, even if the straps become legal again. While it is set, `unit_rst_n`=0, `div_clk_en`=0 and `bypass_clk_en`=1.
- R9: When events are sampled at the same edge, they take effect in this order of priority: illegal strap first, then watchdog expiry, then qualified PCI reset, then clock-count write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_n | input | 1 | External reset pin, active low |
| pll_locked | input | 1 | PLL lock indication |
| pci_rst_n | input | 1 | PCI reset input, active low |
| strap_prom_boot | input | 1 | Boot-from-flash strap |
| strap_rst_dir | input | 1 | Strap letting the PCI reset restart the chip |
| strap_pci_host | input | 1 | PCI boot-host strap |
| clkcnt_wr | input | 1 | One-cycle pulse on software write of the clock-count register |
| wdog_en | input | 1 | Watchdog enable bit |
| wdog_expire | input | 1 | Watchdog expiry pulse |
| bypass_clk_en | output | 1 | Enable for the bypass clock to all units |
| div_clk_en | output | 1 | Enable for the divided unit clock |
| div_tick | output | 1 | One-cycle marker of each divided clock period |
| unit_rst_n | output | 1 | Reset to the units, active low |
| chip_rst | output | 1 | Watchdog chip-reset pulse |
| strap_err | output | 1 | Sticky illegal-strap flag |

## Verification
Every output is decoded from registered state, so any input sampled at an edge shows its effect one cycle later. The bench drives inputs on the falling edge and samples outputs on the next falling edge.

The checks are timed as follows:
- Clock-stop window and watchdog pulse: the bench counts consecutive samples from the first cycle after the trigger and expects exactly 32 and exactly 16.
- Start-up handover: due on the sample right after lock and the external reset release are both present.
- Divider: the bench counts ticks over a fixed 160-cycle span and expects exactly 10.

The bench sweeps all eight strap encodings and repeats the whole sequence for each legal one.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  typedef enum logic [2:0] {
    ST_BYP  = 3'd0,
    ST_RUN  = 3'd1,
    ST_STOP = 3'd2,
    ST_WDR  = 3'd3,
    ST_ERR  = 3'd4
  } rcs_state_e;
endpackage

// File: rtl/rcs_strap_check.sv
module rcs_strap_check (
  input  logic [2:0] straps,
  output logic       illegal
);
  // {prom_boot, rst_dir, pci_host}: rst_dir without flash boot is forbidden
  always_comb begin
    illegal = (straps == 3'b010) || (straps == 3'b011);
  end
endmodule

// File: rtl/rcs_timer.sv
module rcs_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/rcs_divider.sv
module rcs_divider #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!en)            cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick = en && (cnt_q == LAST);
endmodule

// File: rtl/rst_clk_sequencer.sv
module rst_clk_sequencer #(
  parameter int DIV      = 16,
  parameter int STOP_CYC = 32,
  parameter int WD_CYC   = 16
) (
  input  logic clk_ref,
  input  logic por_n,
  input  logic ext_rst_n,
  input  logic pll_locked,
  input  logic pci_rst_n,
  input  logic strap_prom_boot,
  input  logic strap_rst_dir,
  input  logic strap_pci_host,
  input  logic clkcnt_wr,
  input  logic wdog_en,
  input  logic wdog_expire,
  output logic bypass_clk_en,
  output logic div_clk_en,
  output logic div_tick,
  output logic unit_rst_n,
  output logic chip_rst,
  output logic strap_err
);
  import rcs_pkg::*;

  localparam int MAXC = (STOP_CYC > WD_CYC) ? STOP_CYC : WD_CYC;
  localparam int TW   = (MAXC > 2) ? $clog2(MAXC) : 1;
  localparam logic [TW-1:0] STOP_LD = TW'(STOP_CYC - 1);
  localparam logic [TW-1:0] WD_LD   = TW'(WD_CYC - 1);

  rcs_state_e   state_q, state_d;
  logic         err_q;
  logic         illegal;
  logic         tmr_load, tmr_done;
  logic [TW-1:0] tmr_val;
  logic         pci_hit, wd_hit, active;

  rcs_strap_check u_strap (
    .straps  ({strap_prom_boot, strap_rst_dir, strap_pci_host}),
    .illegal (illegal)
  );

  rcs_timer #(.W(TW)) u_timer (
    .clk      (clk_ref),
    .rst_n    (por_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  rcs_divider #(.DIV(DIV)) u_div (
    .clk   (clk_ref),
    .rst_n (por_n),
    .en    (div_clk_en),
    .tick  (div_tick)
  );

  assign pci_hit = strap_rst_dir && !pci_rst_n;
  assign wd_hit  = wdog_en && wdog_expire;
  assign active  = (state_q == ST_RUN) || (state_q == ST_STOP);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = STOP_LD;
    if (illegal || err_q) begin
      state_d = ST_ERR;
    end else if (active && wd_hit) begin
      state_d  = ST_WDR;
      tmr_load = 1'b1;
      tmr_val  = WD_LD;
    end else if (active && pci_hit) begin
      state_d = ST_BYP;
    end else begin
      case (state_q)
        ST_BYP:  if (pll_locked && ext_rst_n && !pci_hit) state_d = ST_RUN;
        ST_RUN:  if (clkcnt_wr) begin
                   state_d  = ST_STOP;
                   tmr_load = 1'b1;
                   tmr_val  = STOP_LD;
                 end
        ST_STOP: if (tmr_done) state_d = ST_RUN;
        ST_WDR:  if (tmr_done) state_d = ST_BYP;
        default: state_d = ST_ERR;
      endcase
    end
  end

  always_ff @(posedge clk_ref or negedge por_n) begin
    if (!por_n) begin
      state_q <= ST_BYP;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_q | illegal;
    end
  end

  assign bypass_clk_en = (state_q == ST_BYP) || (state_q == ST_ERR);
  assign div_clk_en    = (state_q == ST_RUN);
  assign unit_rst_n    = active;
  assign chip_rst      = (state_q == ST_WDR);
  assign strap_err     = err_q;
endmodule

// File: rtl/rst_clk_sequencer_chk.sv
module rst_clk_sequencer_chk #(
  parameter int STOP_CYC = 32,
  parameter int WD_CYC   = 16
) (
  input logic clk_ref,
  input logic por_n,
  input logic ext_rst_n,
  input logic pll_locked,
  input logic bypass_clk_en,
  input logic div_clk_en,
  input logic div_tick,
  input logic unit_rst_n,
  input logic chip_rst,
  input logic strap_err
);
  localparam int CW = $clog2(STOP_CYC + WD_CYC + 4) + 1;

  logic [CW-1:0] gap_q, wd_q;

  // length of the current clock-stop window (units out of reset, divided clock off)
  always_ff @(posedge clk_ref or negedge por_n) begin
    if (!por_n) gap_q <= '0;
    else if (div_clk_en || !unit_rst_n) gap_q <= '0;
    else if (gap_q != '1) gap_q <= gap_q + 1'b1;
  end

  // length of the current chip-reset pulse
  always_ff @(posedge clk_ref or negedge por_n) begin
    if (!por_n) wd_q <= '0;
    else if (!chip_rst) wd_q <= '0;
    else if (wd_q != '1) wd_q <= wd_q + 1'b1;
  end

  assert_one_clk_src_R2: assert property (@(posedge clk_ref) disable iff (!por_n)
    !(bypass_clk_en && div_clk_en));

  assert_start_gate_R2: assert property (@(posedge clk_ref) disable iff (!por_n)
    ($rose(div_clk_en) && $past(bypass_clk_en)) |-> $past(pll_locked && ext_rst_n));

  assert_tick_in_run_R3: assert property (@(posedge clk_ref) disable iff (!por_n)
    div_tick |-> div_clk_en);

  assert_rst_with_clk_R4: assert property (@(posedge clk_ref) disable iff (!por_n)
    ($rose(unit_rst_n) |-> div_clk_en));

  assert_stop_len_R5: assert property (@(posedge clk_ref) disable iff (!por_n)
    ($rose(div_clk_en) && $past(unit_rst_n)) |-> (gap_q == CW'(STOP_CYC)));

  assert_wd_len_R7: assert property (@(posedge clk_ref) disable iff (!por_n)
    $fell(chip_rst) |-> (wd_q == CW'(WD_CYC)));

  assert_wd_holds_R7: assert property (@(posedge clk_ref) disable iff (!por_n)
    chip_rst |-> (!unit_rst_n && !div_clk_en && !bypass_clk_en));

  assert_err_sticky_R8: assert property (@(posedge clk_ref) disable iff (!por_n)
    strap_err |=> strap_err);

  assert_err_holds_R8: assert property (@(posedge clk_ref) disable iff (!por_n)
    strap_err |-> (!unit_rst_n && bypass_clk_en));
endmodule

bind rst_clk_sequencer rst_clk_sequencer_chk #(.STOP_CYC(STOP_CYC), .WD_CYC(WD_CYC)) chk_i (
  .clk_ref       (clk_ref),
  .por_n         (por_n),
  .ext_rst_n     (ext_rst_n),
  .pll_locked    (pll_locked),
  .bypass_clk_en (bypass_clk_en),
  .div_clk_en    (div_clk_en),
  .div_tick      (div_tick),
  .unit_rst_n    (unit_rst_n),
  .chip_rst      (chip_rst),
  .strap_err     (strap_err)
);

// File: tb/rst_clk_sequencer_tb_top.sv
`timescale 1ns/1ps
module rst_clk_sequencer_tb_top;
  logic clk_ref = 1'b0;
  logic por_n = 1'b0, ext_rst_n = 1'b0, pll_locked = 1'b0, pci_rst_n = 1'b1;
  logic strap_prom_boot = 1'b0, strap_rst_dir = 1'b0, strap_pci_host = 1'b0;
  logic clkcnt_wr = 1'b0, wdog_en = 1'b0, wdog_expire = 1'b0;
  logic bypass_clk_en, div_clk_en, div_tick, unit_rst_n, chip_rst, strap_err;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_ref = ~clk_ref;

  rst_clk_sequencer dut_i (
    .clk_ref(clk_ref), .por_n(por_n), .ext_rst_n(ext_rst_n), .pll_locked(pll_locked),
    .pci_rst_n(pci_rst_n), .strap_prom_boot(strap_prom_boot), .strap_rst_dir(strap_rst_dir),
    .strap_pci_host(strap_pci_host), .clkcnt_wr(clkcnt_wr), .wdog_en(wdog_en),
    .wdog_expire(wdog_expire), .bypass_clk_en(bypass_clk_en), .div_clk_en(div_clk_en),
    .div_tick(div_tick), .unit_rst_n(unit_rst_n), .chip_rst(chip_rst), .strap_err(strap_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk_ref);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog timeout actual=1 expected=0");
    finish_run();
  end

  initial begin
    for (int s = 0; s < 8; s++) begin
      // encodings 010 and 011 are illegal
      bit legal;
      int n;
      legal = !((s[2] == 1'b0) && (s[1] == 1'b1));
      nxt();
      por_n = 1'b0; ext_rst_n = 1'b0; pll_locked = 1'b0; pci_rst_n = 1'b1;
      clkcnt_wr = 1'b0; wdog_en = 1'b0; wdog_expire = 1'b0;
      {strap_prom_boot, strap_rst_dir, strap_pci_host} = 3'(s);
      nxt();
      chk("R1 bypass in reset", bypass_clk_en, 1);
      chk("R1 unit reset in reset", unit_rst_n, 0);
      chk("R1 err clear in reset", strap_err, 0);
      por_n = 1'b1;
      nxt();
      nxt();
      if (!legal) begin
        chk("R8 illegal strap flagged", strap_err, 1);
        chk("R8 units held", unit_rst_n, 0);
        chk("R8 bypass on", bypass_clk_en, 1);
        pll_locked = 1'b1; ext_rst_n = 1'b1;
        {strap_prom_boot, strap_rst_dir, strap_pci_host} = 3'b100;
        for (int k = 0; k < 5; k++) nxt();
        chk("R8 sticky after legal straps", strap_err, 1);
        chk("R8 no run while err", div_clk_en, 0);
        continue;
      end
      chk("R1 bypass after reset", bypass_clk_en, 1);
      chk("R1 div off after reset", div_clk_en, 0);
      chk("R1 no chip reset", chip_rst, 0);
      pll_locked = 1'b1;
      for (int k = 0; k < 3; k++) nxt();
      chk("R2 wait for ext reset", div_clk_en, 0);
      pll_locked = 1'b0; ext_rst_n = 1'b1;
      for (int k = 0; k < 3; k++) nxt();
      chk("R2 wait for lock", div_clk_en, 0);
      pll_locked = 1'b1;
      nxt();
      chk("R2 divided clock on", div_clk_en, 1);
      chk("R2 bypass off", bypass_clk_en, 0);
      chk("R4 reset released with clock", unit_rst_n, 1);
      n = 0;
      for (int k = 0; k < 160; k++) begin
        nxt();
        if (div_tick) n++;
      end
      chk("R3 ticks in 160 cycles", n, 10);

      // R5 clock stop window with a second write ignored
      clkcnt_wr = 1'b1;
      nxt();
      clkcnt_wr = 1'b0;
      n = 0;
      while (!div_clk_en && n < 100) begin
        if (!unit_rst_n || bypass_clk_en) chk("R5 units stay out of reset", 0, 1);
        if (n == 10) clkcnt_wr = 1'b1;
        nxt();
        clkcnt_wr = 1'b0;
        n++;
      end
      chk("R5 stop length", n, 32);

      // R6 PCI reset
      pci_rst_n = 1'b0;
      nxt();
      if (s[1]) begin
        chk("R6 pci reset to bypass", bypass_clk_en, 1);
        chk("R6 pci reset units", unit_rst_n, 0);
        nxt();
        chk("R6 held while pci low", div_clk_en, 0);
        pci_rst_n = 1'b1;
        nxt();
        chk("R6 restart after pci", div_clk_en, 1);
      end else begin
        nxt();
        chk("R6 pci ignored", div_clk_en, 1);
        pci_rst_n = 1'b1;
        nxt();
      end

      // R7 watchdog ignored when disabled
      wdog_expire = 1'b1;
      nxt();
      wdog_expire = 1'b0;
      chk("R7 disabled watchdog ignored", chip_rst, 0);
      chk("R7 disabled run kept", div_clk_en, 1);

      // R9 simultaneous events: watchdog wins over pci and clock write
      wdog_en = 1'b1; wdog_expire = 1'b1; clkcnt_wr = 1'b1; pci_rst_n = 1'b0;
      nxt();
      wdog_expire = 1'b0; clkcnt_wr = 1'b0; pci_rst_n = 1'b1;
      chk("R9 watchdog has priority", chip_rst, 1);
      n = 0;
      while (chip_rst && n < 50) begin
        if (unit_rst_n || div_clk_en || bypass_clk_en) chk("R7 all off in chip reset", 0, 1);
        nxt();
        n++;
      end
      chk("R7 chip reset length", n, 16);
      chk("R7 back to bypass", bypass_clk_en, 1);
      nxt();
      chk("R7 restart after chip reset", div_clk_en, 1);

      // R9 illegal strap beats watchdog
      wdog_expire = 1'b1;
      {strap_prom_boot, strap_rst_dir, strap_pci_host} = 3'b010;
      nxt();
      wdog_expire = 1'b0;
      chk("R9 strap error over watchdog", strap_err, 1);
      chk("R9 no chip reset", chip_rst, 0);
      chk("R8 units held mid run", unit_rst_n, 0);
    end
    finish_run();
  end
endmodule